// File: doc/BRIEF.md
# Two-Stage Interrupt Flag and Pending Controller

This block collects interrupt events from a set of peripherals and presents one request per line to a processor core. The first stage holds, for every peripheral, a word of latched flags. Hardware events and software writes set these flags, and software writes clear them. Each flag has its own mask bit. The unmasked flags of a peripheral are OR-combined into that peripheral's request line.

The second stage holds one sticky pending bit per line. A high request line sets it. Software can also set it as a software-generated interrupt, or clear it. An acknowledge pulse from the core also clears it. The pending bit is gated by a per-line enable to form the request to the core. Software reaches every register through a simple word-addressed bus with single-cycle writes and combinational read data.

Each peripheral page spans four words at word address `4*p`:
- offset 0: flag status, read-only.
- offset 1: flag set.
- offset 2: flag clear.
- offset 3: flag mask, read/write.

The line page sits at `4*NL`:
- offset 0: pending set.
- offset 1: pending clear.
- offset 2: line-enable set.
- offset 3: line-enable clear.

Top module: `irq_flag_pend`

## Requirements
- R1: A high bit of `hw_evt` (bit `p*NF+j` is flag j of peripheral p) sets that flag at the next clock edge. The flag then stays set until software clears it.
- R2: Writing ones to flag-set (offset 1) sets those flags, and writing ones to flag-clear (offset 2) clears them. Zero bits leave flags unchanged. Reading offsets 0, 1 or 2 of a page returns the current flags in bits NF-1:0, with upper bits zero.
- R3: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R4: `periph_req[p]` is high exactly when some flag of peripheral p and its mask bit are both set.
- R5: A high `periph_req[i]` sets pending bit i at the next edge. The bit stays set after the line falls.
- R6: Ones written to pending-set set pending bits. Ones written to pending-clear, or a high `ack[i]`, release them. A line that is still high keeps its pending bit set. Reading the pending-set or pending-clear address returns the pending bits.
- R7: `irq[i]` equals pending bit i ANDed with line enable i. Line enables are set by ones written to enable-set and cleared by ones written to enable-clear, and set wins over clear. Reading either enable address returns the enables.
- R8: Synchronous reset clears all flags, masks, pending bits and enables, so `irq`, `periph_req` and all reads are zero.
- R9: A write to a mask register (offset 3) replaces the mask with bits NF-1:0 of the data, and reading it returns that mask.
- R10: Word addresses above `4*NL+3` read zero, and writes to them change nothing. Writes to the status offset 0 also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr |
| hw_evt | input | NL*NF | Hardware event per flag |
| ack | input | NL | Core acknowledge per line, clears pending |
| periph_req | output | NL | Masked OR of each peripheral's flags |
| irq | output | NL | Pending and enabled request to the core |

## Verification
A corrupted flag or mask shows up on `periph_req` in the same cycle it is wrong, and on `irq` one edge later through the pending bit. A lost or stuck pending bit shows on `irq` whenever the line is enabled. It also shows at once on a read of the line page, even while the line is disabled. The bench therefore compares both request vectors against a reference model every cycle and reads back a register each cycle, so a wrong state appears within one or two cycles of the fault.

// File: rtl/irq_flag_pend.sv
module irq_flag_pend #(
  parameter int NL = 4,
  parameter int NF = 8,
  parameter int DW = 32,
  parameter int AW = $clog2(NL*4 + 4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NL*NF-1:0] hw_evt,
  input  logic [NL-1:0]    ack,
  output logic [NL-1:0]    periph_req,
  output logic [NL-1:0]    irq
);
  localparam int PW = AW - 2;

  logic [NL*NF-1:0] flag_q, mask_q;
  logic [NL-1:0]    pend_q, len_q;
  logic [PW-1:0]    page;
  logic [1:0]       sub;
  logic             line_pg;

  assign page    = bus_addr[AW-1:2];
  assign sub     = bus_addr[1:0];
  assign line_pg = bus_we && page == PW'(NL);

  for (genvar p = 0; p < NL; p++) begin : g_per
    logic          pg;
    logic [NF-1:0] fset, fclr;
    assign pg   = bus_we && page == PW'(p);
    assign fset = (pg && sub == 2'd1) ? bus_wdata[NF-1:0] : '0;
    assign fclr = (pg && sub == 2'd2) ? bus_wdata[NF-1:0] : '0;
    assign periph_req[p] = |(flag_q[p*NF +: NF] & mask_q[p*NF +: NF]);

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[p*NF +: NF] <= '0;
        mask_q[p*NF +: NF] <= '0;
      end else begin
        flag_q[p*NF +: NF] <= (flag_q[p*NF +: NF] & ~fclr) | fset | hw_evt[p*NF +: NF];
        if (pg && sub == 2'd3) mask_q[p*NF +: NF] <= bus_wdata[NF-1:0];
      end
    end
  end

  logic [NL-1:0] pset, pclr, lset, lclr;
  assign pset = (line_pg && sub == 2'd0) ? bus_wdata[NL-1:0] : '0;
  assign pclr = (line_pg && sub == 2'd1) ? bus_wdata[NL-1:0] : '0;
  assign lset = (line_pg && sub == 2'd2) ? bus_wdata[NL-1:0] : '0;
  assign lclr = (line_pg && sub == 2'd3) ? bus_wdata[NL-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      len_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pclr & ~ack) | pset | periph_req;
      len_q  <= (len_q & ~lclr) | lset;
    end
  end

  assign irq = pend_q & len_q;

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NL; p++)
      if (page == PW'(p))
        bus_rdata[NF-1:0] = (sub == 2'd3) ? mask_q[p*NF +: NF] : flag_q[p*NF +: NF];
    if (page == PW'(NL))
      bus_rdata[NL-1:0] = sub[1] ? len_q : pend_q;
  end
endmodule

// File: rtl/irq_flag_pend_chk.sv
module irq_flag_pend_chk #(
  parameter int NL = 4,
  parameter int NF = 8,
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [NL*NF-1:0] hw_evt,
  input logic [NL-1:0]    ack,
  input logic [NL-1:0]    periph_req,
  input logic [NL-1:0]    irq,
  input logic [NL*NF-1:0] flag_q,
  input logic [NL-1:0]    pend_q,
  input logic [NL-1:0]    len_q
);
  localparam logic [AW-1:0] A_PSET = AW'(NL*4);
  localparam logic [AW-1:0] A_PCLR = AW'(NL*4 + 1);
  localparam logic [AW-1:0] A_LSET = AW'(NL*4 + 2);

  logic [NL-1:0] psw, pcw, lsw;
  assign psw = (bus_we && bus_addr == A_PSET) ? bus_wdata[NL-1:0] : '0;
  assign pcw = (bus_we && bus_addr == A_PCLR) ? bus_wdata[NL-1:0] : '0;
  assign lsw = (bus_we && bus_addr == A_LSET) ? bus_wdata[NL-1:0] : '0;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (irq == '0 && periph_req == '0)); // R8

  for (genvar j = 0; j < NL*NF; j++) begin : g_f
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst) hw_evt[j] |=> flag_q[j]); // R3
  end

  for (genvar i = 0; i < NL; i++) begin : g_l
    AST_LINE_LATCH: assert property (@(posedge clk) disable iff (rst) periph_req[i] |=> pend_q[i]); // R5
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !ack[i] && !pcw[i]) |=> pend_q[i]); // R5
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && !periph_req[i] && !psw[i]) |=> !pend_q[i]); // R6
    AST_EN_NEEDS_SET: assert property (@(posedge clk) disable iff (rst)
      $rose(len_q[i]) |-> $past(lsw[i])); // R7
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> pend_q[i]); // R7
  end
endmodule

bind irq_flag_pend irq_flag_pend_chk #(.NL(NL), .NF(NF), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .hw_evt(hw_evt), .ack(ack), .periph_req(periph_req), .irq(irq),
  .flag_q(flag_q), .pend_q(pend_q), .len_q(len_q)
);

// File: tb/irq_flag_pend_test.sv
module irq_flag_pend_test;
  localparam int NL = 4, NF = 8, DW = 32, AW = 5;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [NL*NF-1:0] hw_evt = '0;
  logic [NL-1:0] ack = '0, periph_req, irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [NF-1:0] mf [NL];
  logic [NF-1:0] mm [NL];
  logic [NL-1:0] mp, ml;

  irq_flag_pend #(.NL(NL), .NF(NF), .DW(DW), .AW(AW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NL-1:0] m_line();
    logic [NL-1:0] r;
    for (int p = 0; p < NL; p++) r[p] = |(mf[p] & mm[p]);
    return r;
  endfunction

  function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    int pg = int'(a) >> 2;
    int sb = int'(a) & 3;
    if (pg < NL) r[NF-1:0] = (sb == 3) ? mm[pg] : mf[pg];
    else if (pg == NL) r[NL-1:0] = (sb >= 2) ? ml : mp;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [NL*NF-1:0] h, input logic [NL-1:0] k);
    logic [NL-1:0] ln, ps, pc, ls, lc;
    ln = m_line();
    for (int p = 0; p < NL; p++) begin
      logic [NF-1:0] fs, fc;
      fs = (we && int'(a) == p*4+1) ? d[NF-1:0] : '0;
      fc = (we && int'(a) == p*4+2) ? d[NF-1:0] : '0;
      mf[p] = (mf[p] & ~fc) | fs | h[p*NF +: NF];
      if (we && int'(a) == p*4+3) mm[p] = d[NF-1:0];
    end
    ps = (we && int'(a) == NL*4)   ? d[NL-1:0] : '0;
    pc = (we && int'(a) == NL*4+1) ? d[NL-1:0] : '0;
    ls = (we && int'(a) == NL*4+2) ? d[NL-1:0] : '0;
    lc = (we && int'(a) == NL*4+3) ? d[NL-1:0] : '0;
    mp = (mp & ~pc & ~k) | ps | ln;
    ml = (ml & ~lc) | ls;
  endtask

  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [NL*NF-1:0] h, input logic [NL-1:0] k);
    bus_we = we; bus_addr = a; bus_wdata = d; hw_evt = h; ack = k;
    @(posedge clk);
    model_step(we, a, d, h, k);
    @(negedge clk);
    bus_we = 0; hw_evt = '0; ack = '0;
    #1;
    chk("R4 periph_req", DW'(periph_req), DW'(m_line()));
    chk("R7 irq", DW'(irq), DW'(mp & ml));
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < (1 << AW); a++) rd(AW'(a), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < NL; p++) begin mf[p] = '0; mm[p] = '0; end
    mp = '0; ml = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R8 irq after reset", DW'(irq), '0);
    chk("R8 periph_req after reset", DW'(periph_req), '0);
    rd_all("R8 reads after reset");

    cyc(1, 5'd3, 32'h0000_00A5, '0, '0);
    rd(5'd3, "R9 mask readback");
    cyc(1, 5'd3, 32'hFFFF_FF01, '0, '0);
    rd(5'd3, "R9 mask replaced");

    cyc(0, '0, '0, 32'h0000_0001, '0);
    chk("R1 flag set by event", DW'(periph_req[0]), 1);
    repeat (3) cyc(0, '0, '0, '0, '0);
    rd(5'd0, "R1 flag held");
    cyc(1, 5'd1, 32'h0, '0, '0);
    rd(5'd1, "R2 zero set write no effect");
    cyc(1, 5'd2, 32'h0, '0, '0);
    rd(5'd2, "R2 zero clear write no effect");

    cyc(1, AW'(NL*4+2), 32'h1, '0, '0);
    cyc(1, 5'd2, 32'h1, '0, '0);
    chk("R5 line dropped", DW'(periph_req[0]), 0);
    cyc(0, '0, '0, '0, '0);
    chk("R5 pending sticky", DW'(irq[0]), 1);
    rd(AW'(NL*4), "R6 pending readback");

    cyc(0, '0, '0, '0, 4'b0001);
    chk("R6 ack releases", DW'(irq[0]), 0);

    cyc(1, 5'd2, 32'h1, 32'h1, '0);
    rd(5'd0, "R3 hw wins over clear");
    chk("R3 flag kept", DW'(bus_rdata[0]), 1);
    cyc(1, AW'(NL*4+1), 32'h1, '0, '0);
    chk("R6 relatch while line high", DW'(irq[0]), 1);
    cyc(1, 5'd2, 32'h1, '0, '0);
    cyc(1, AW'(NL*4+1), 32'h1, '0, '0);
    chk("R6 clear after line low", DW'(irq[0]), 0);

    cyc(1, AW'(NL*4), 32'h4, '0, '0);
    cyc(1, AW'(NL*4+2), 32'h4, '0, '0);
    chk("R6 software pending set", DW'(irq[2]), 1);
    cyc(1, AW'(NL*4+3), 32'h4, '0, '0);
    chk("R7 enable cleared gates irq", DW'(irq[2]), 0);

    cyc(1, 5'd20, 32'hFFFF_FFFF, '0, '0);
    cyc(1, 5'd31, 32'hFFFF_FFFF, '0, '0);
    cyc(1, 5'd4, 32'hFFFF_FFFF, '0, '0);
    rd_all("R10 unused and status writes ignored");

    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      we = ($urandom % 3) != 0;
      a  = AW'($urandom % (NL*4 + 6));
      d  = $urandom;
      cyc(we, a, d, NL*NF'($urandom & $urandom & $urandom & $urandom),
          NL'($urandom & $urandom & $urandom));
      rd(AW'($urandom), "R2 random readback");
    end
    rd_all("R2 final readback");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule